// File: doc/BRIEF.md
# Split Decade Counter with Gated Clear and Preset-to-Nine

This block is a four-bit counter made of two sections with separate count inputs. A one-bit section divides its count input by two and drives bit 0 of the output. A three-bit section divides its own count input by five and drives bits 3..1. Both count inputs are sampled in the system clock domain. A section advances on the clock edge where its input is first seen low after being high.

Two pairs of gated controls override counting. When both inputs of the clear pair are high, the whole output is forced to zero. When both inputs of the preset pair are high, the output is forced to nine, and this wins over clear.

Both configurations are wired outside the block. Feeding output bit 0 back into the five-section input and counting on the two-section input gives BCD counting. Feeding output bit 3 into the two-section input and counting on the five-section input gives a symmetric divide-by-ten square wave on bit 0.

Top module: `split_decade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0 at once, without waiting for a clock edge.
- R2: With `clr_a_i` and `clr_b_i` both high and the preset pair not both high, `q_o` is 0 after the next clock edge.
- R3: A single high input in either control pair has no effect on `q_o`; counting continues as normal.
- R4: With `nine_a_i` and `nine_b_i` both high, `q_o` is 4'b1001 after the next clock edge, whatever the clear pair does.
- R5: `q_o[0]` toggles on the clock edge where `cnt_a_i` is first sampled low after being sampled high. Rising edges and steady levels leave it unchanged.
- R6: `q_o[3:1]` advances 000, 001, 010, 011, 100 and back to 000 on the clock edge where `cnt_b_i` is first sampled low after being sampled high. It holds otherwise.
- R7: Count-input falling edges seen while either override is active are discarded and are not replayed later. Counting resumes from the forced value on the first falling edge after the release.
- R8: With `q_o[0]` wired to `cnt_b_i` and pulses on `cnt_a_i`, `q_o` read as a binary number steps 0 to 9 and wraps to 0.
- R9: With `q_o[3]` wired to `cnt_a_i` and pulses on `cnt_b_i`, `q_o[0]` is high for exactly 5 of every 10 pulses, switching after pulses 5 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_a_i | input | 1 | Count input of the divide-by-two section |
| cnt_b_i | input | 1 | Count input of the divide-by-five section |
| clr_a_i | input | 1 | Clear gate, first input |
| clr_b_i | input | 1 | Clear gate, second input |
| nine_a_i | input | 1 | Preset-to-nine gate, first input |
| nine_b_i | input | 1 | Preset-to-nine gate, second input |
| q_o | output | 4 | Count; bit 0 from the two-section, bits 3..1 from the five-section |

## Verification
Two functions can fall in the same cycle: a count-input falling edge together with an active override, and clear together with preset-to-nine. The bench provokes the first by dropping a count input in a cycle where a control pair is fully high. It passes only if the output shows the forced value and the next cycle after release shows no late step. The bench provokes the second by raising all four control inputs at once and requires the output to read nine.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
  localparam int unsigned LO_BITS    = 1;
  localparam int unsigned HI_BITS    = 3;
  localparam int unsigned OUT_BITS   = LO_BITS + HI_BITS;
  localparam int unsigned LO_MODULUS = 2;
  localparam int unsigned HI_MODULUS = 5;
  localparam int unsigned NUM_CNT_IN = 2;
  localparam logic [OUT_BITS-1:0] NINE_CODE = OUT_BITS'(9);
  localparam logic [LO_BITS-1:0]  NINE_LO   = NINE_CODE[LO_BITS-1:0];
  localparam logic [HI_BITS-1:0]  NINE_HI   = NINE_CODE[OUT_BITS-1:LO_BITS];

  typedef enum logic [1:0] {
    OVR_NONE  = 2'd0,
    OVR_CLEAR = 2'd1,
    OVR_NINE  = 2'd2
  } ovr_e;
endpackage

// File: rtl/scnt_fall_detect.sv
module scnt_fall_detect #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din_i,
  output logic [NCH-1:0] fall_o
);
  logic [NCH-1:0] prev_r;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_r[g] <= 1'b0;
      else        prev_r[g] <= din_i[g];
    end
    // falling edge: was high last cycle, low now
    assign fall_o[g] = prev_r[g] & ~din_i[g];
  end
endmodule

// File: rtl/scnt_override_dec.sv
module scnt_override_dec
  import scnt_pkg::*;
(
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic nine_a_i,
  input  logic nine_b_i,
  output ovr_e ovr_o
);
  logic clr_gate, nine_gate;

  always_comb begin
    clr_gate  = clr_a_i & clr_b_i;
    nine_gate = nine_a_i & nine_b_i;
    if (nine_gate)     ovr_o = OVR_NINE;   // preset wins
    else if (clr_gate) ovr_o = OVR_CLEAR;
    else               ovr_o = OVR_NONE;
  end
endmodule

// File: rtl/scnt_stage.sv
module scnt_stage
  import scnt_pkg::*;
#(
  parameter int unsigned     WIDTH    = 1,
  parameter int unsigned     MODULUS  = 2,
  parameter logic [WIDTH-1:0] NINE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  ovr_e             ovr_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] q_r, q_nxt;
  logic             q_en;

  // next state: override first, then count; codes at or past LAST wrap to 0
  always_comb begin
    q_en  = 1'b0;
    q_nxt = q_r;
    case (ovr_i)
      OVR_NINE: begin
        q_en  = 1'b1;
        q_nxt = NINE_VAL;
      end
      OVR_CLEAR: begin
        q_en  = 1'b1;
        q_nxt = '0;
      end
      default: begin
        if (step_i) begin
          q_en  = 1'b1;
          q_nxt = (q_r >= LAST) ? '0 : q_r + WIDTH'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import scnt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_a_i,
  input  logic                cnt_b_i,
  input  logic                clr_a_i,
  input  logic                clr_b_i,
  input  logic                nine_a_i,
  input  logic                nine_b_i,
  output logic [OUT_BITS-1:0] q_o
);
  logic [NUM_CNT_IN-1:0] fall;
  ovr_e                  ovr;
  logic [LO_BITS-1:0]    lo_q;
  logic [HI_BITS-1:0]    hi_q;

  scnt_fall_detect #(.NCH(NUM_CNT_IN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  ({cnt_b_i, cnt_a_i}),
    .fall_o (fall)
  );

  scnt_override_dec u_ovr (
    .clr_a_i  (clr_a_i),
    .clr_b_i  (clr_b_i),
    .nine_a_i (nine_a_i),
    .nine_b_i (nine_b_i),
    .ovr_o    (ovr)
  );

  scnt_stage #(.WIDTH(LO_BITS), .MODULUS(LO_MODULUS), .NINE_VAL(NINE_LO)) u_lo (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (fall[0]),
    .ovr_i  (ovr),
    .q_o    (lo_q)
  );

  scnt_stage #(.WIDTH(HI_BITS), .MODULUS(HI_MODULUS), .NINE_VAL(NINE_HI)) u_hi (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (fall[1]),
    .ovr_i  (ovr),
    .q_o    (hi_q)
  );

  assign q_o = {hi_q, lo_q};
endmodule

// File: rtl/scnt_checker.sv
module scnt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_a_i,
  input logic       cnt_b_i,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       nine_a_i,
  input logic       nine_b_i,
  input logic [3:0] q_o
);
  logic a_seen, b_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen <= 1'b0;
      b_seen <= 1'b0;
    end else begin
      a_seen <= cnt_a_i;
      b_seen <= cnt_b_i;
    end
  end

  wire nine_on = nine_a_i & nine_b_i;
  wire clr_on  = clr_a_i & clr_b_i;
  wire free    = !nine_on && !clr_on;
  wire a_drop  = a_seen && !cnt_a_i;
  wire b_drop  = b_seen && !cnt_b_i;

  AST_NINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nine_on |=> q_o == 4'd9);                                   // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on && !nine_on) |=> q_o == 4'd0);                      // R2
  AST_LO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (free && a_drop) |=> q_o[0] != $past(q_o[0]));              // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !a_drop) |=> $stable(q_o[0]));                     // R5
  AST_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (free && b_drop && q_o[3:1] == 3'd4) |=> q_o[3:1] == 3'd0); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !b_drop) |=> $stable(q_o[3:1]));                   // R6
endmodule

bind split_decade_counter scnt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_a_i  (cnt_a_i),
  .cnt_b_i  (cnt_b_i),
  .clr_a_i  (clr_a_i),
  .clr_b_i  (clr_b_i),
  .nine_a_i (nine_a_i),
  .nine_b_i (nine_b_i),
  .q_o      (q_o)
);

// File: tb/tb_split_decade_counter.sv
module tb_split_decade_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_drv = 1'b0, b_drv = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [1:0] mode = 2'd0;   // 0 direct, 1 BCD wiring, 2 divide-by-ten wiring
  logic [3:0] q;
  logic       cnt_a, cnt_b;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign cnt_a = (mode == 2'd2) ? q[3] : a_drv;
  assign cnt_b = (mode == 2'd1) ? q[0] : b_drv;

  split_decade_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
    .q_o(q)
  );

  // {clr_a, clr_b, nine_a, nine_b, a, b, expected q}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b000000_0000,  // idle                         R5
    10'b000010_0000,  // A rises: no step             R5
    10'b000000_0001,  // A falls: toggle              R5
    10'b000001_0001,  // B rises                      R6
    10'b000000_0011,  // B falls: hi=1                R6
    10'b100001_0011,  // single clear input           R3
    10'b100000_0101,  // counts despite it: hi=2      R3
    10'b001010_0101,  // single preset input          R3
    10'b001000_0100,  // A falls, still counts        R3
    10'b110010_0000,  // clear pair                   R2
    10'b110000_0000,  // A falls under clear          R7
    10'b000000_0000,  // release: no replay           R7
    10'b111101_1001,  // all four high: nine          R4
    10'b111100_1001,  // B falls under preset         R7
    10'b000000_1001,  // release                      R7
    10'b000001_1001,  // B rises                      R6
    10'b000000_0001,  // B falls: hi 4 -> 0           R6
    10'b001101_1001,  // preset pair alone            R4
    10'b000000_0001   // release with B fall: resume  R7
  };

  task automatic check(input logic ok, input string req,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit on_a);
    if (on_a) a_drv = 1'b1; else b_drv = 1'b1;
    repeat (2) @(negedge clk);
    if (on_a) a_drv = 1'b0; else b_drv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(q == 4'd0, "R1", q, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(q == 4'd0, "R1", q, 4'd0);

    for (int i = 0; i < NV; i++) begin
      {clr_a, clr_b, nine_a, nine_b, a_drv, b_drv} = VEC[i][9:4];
      @(posedge clk);
      @(negedge clk);
      check(q == VEC[i][3:0], "R2-R7 table", q, VEC[i][3:0]);
    end

    // R1: reset acts without a clock edge
    #2 rst_n = 1'b0;
    #1 check(q == 4'd0, "R1 async", q, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: BCD wiring
    mode = 2'd1;
    for (int k = 1; k <= 20; k++) begin
      pulse(1'b1);
      check(q == 4'(k % 10), "R8", q, 4'(k % 10));
    end

    // R9: divide-by-ten wiring
    do_reset();
    mode = 2'd2;
    begin
      int s = 0;
      logic qa = 1'b0;
      int highs = 0;
      for (int k = 1; k <= 20; k++) begin
        pulse(1'b0);
        if (s == 4) qa = ~qa;
        s = (s + 1) % 5;
        check(q == {3'(s), qa}, "R9", q, {3'(s), qa});
        if (k <= 10 && q[0]) highs++;
      end
      check(highs == 5, "R9 duty", 4'(highs), 4'd5);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule